// File: doc/BRIEF.md
# Local Interrupt Acceptance Unit

This block sits between an interrupt message path and a processor core. Each message carries a vector number. The unit decides at once whether to take the message, and answers with a one-cycle accept or reject pulse. Taken messages are held in a per-vector pending store. The highest pending vector is handed to the core when its priority class beats the current processor priority. A handed-over vector stays in service until the core signals end of interrupt.

The processor priority follows a software-written task priority. While a handler of a higher class is in service, it takes that handler's class instead. A vector that is already pending or in service is always taken, whatever the task priority. Up to two occurrences of each vector are stored, so a second arrival while the first waits or runs is not lost. Vectors below 0x10 are not valid on this path. They are refused, and a sticky error flag is raised.

Top module: `irq_accept_unit`

## Requirements
- R1: After reset, nothing is pending or in service, the task priority is 0x00, `proc_prio` reads 0x00, and `rsp_accept`, `rsp_reject`, `irq_pulse` and `illegal_err` are low.
- R2: A message whose vector is below 0x10 is rejected. From the following cycle, `illegal_err` is high, and it stays high until reset.
- R3: A message with a vector of 0x10 or above, not pending and not in service, is accepted when its class (vector bits 7:4) is strictly greater than the task-priority class (task priority bits 7:4). Otherwise it is rejected.
- R4: A message with a vector of 0x10 or above whose vector is already pending or in service is accepted regardless of the task priority, provided fewer than two occurrences of it are pending.
- R5: Each vector holds at most two pending occurrences. A message that finds two already pending is rejected and changes nothing.
- R6: When the greatest pending vector number has a class strictly greater than the `proc_prio` class, that vector is dispatched. In the next cycle `irq_pulse` is high for one cycle and `irq_vec` holds the vector until the next dispatch. The vector enters service, and its pending count drops by one. At most one dispatch happens per cycle.
- R7: `proc_prio` equals the task priority when the task-priority class is at least the class of the highest in-service vector. Otherwise it equals that in-service class in bits 7:4, with bits 3:0 zero. The task priority changes only through the write port, one cycle after `tpr_we`.
- R8: An `eoi` strobe removes the highest-numbered in-service vector, and `proc_prio` is recomputed from what remains.
- R9: Each message gets exactly one of `rsp_accept` or `rsp_reject`, one cycle after `msg_valid`. Neither is asserted in any other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| msg_valid | input | 1 | An interrupt message is present this cycle |
| msg_vec | input | 8 | Vector number of the message |
| tpr_we | input | 1 | Software write strobe for the task priority |
| tpr_wdata | input | 8 | New task priority value |
| eoi | input | 1 | End of interrupt from the core |
| rsp_accept | output | 1 | Message of the previous cycle was taken |
| rsp_reject | output | 1 | Message of the previous cycle was refused |
| irq_pulse | output | 1 | A vector was dispatched to the core |
| irq_vec | output | 8 | Most recently dispatched vector |
| proc_prio | output | 8 | Current processor priority |
| illegal_err | output | 1 | Sticky: a vector below 0x10 was seen |

## Verification
The properties assume that `eoi` is only pulsed while some vector is in service. They also assume that `msg_vec` is meaningful only while `msg_valid` is high. Under that assumption, the dispatched class can never exceed the priority that results from the dispatch. The random stimulus pulses `eoi` freely, and an empty in-service store simply ignores it. About a fifth of the vectors are drawn below 0x10, and a share are replayed from recently accepted ones, so that focus acceptance and the two-occurrence limit are reached often. Task-priority writes sweep the full range, so dispatch is both blocked and allowed.

// File: rtl/iau_pkg.sv
package iau_pkg;
   // Reason behind an acceptance decision for one message
   typedef enum logic [2:0] {
      DEC_NONE,
      DEC_ILLEGAL,
      DEC_FULL,
      DEC_FOCUS,
      DEC_PRIO_OK,
      DEC_PRIO_LOW
   } iau_dec_e;

   function automatic logic dec_takes(input iau_dec_e d);
      return (d == DEC_FOCUS) || (d == DEC_PRIO_OK);
   endfunction
endpackage

// File: rtl/iau_top_finder.sv
// Index of the highest set bit of a vector, plus an any-set flag
module iau_top_finder #(
   parameter int N  = 256,
   parameter int IW = 8
) (
   input  logic [N-1:0]  bits_i,
   output logic          any_o,
   output logic [IW-1:0] idx_o
);
   initial begin
      if (N > (1 << IW)) $error("iau_top_finder: index too narrow");
   end

   always_comb begin
      any_o = 1'b0;
      idx_o = '0;
      for (int i = 0; i < N; i++) begin
         if (bits_i[i]) begin
            any_o = 1'b1;
            idx_o = IW'(i);
         end
      end
   end
endmodule

// File: rtl/iau_occ_bank.sv
// Per-vector occurrence store: pending flag and full flag per vector
module iau_occ_bank #(
   parameter int N         = 256,
   parameter int IW        = 8,
   parameter int OCC_DEPTH = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          inc_en,
   input  logic [IW-1:0] inc_idx,
   input  logic          dec_en,
   input  logic [IW-1:0] dec_idx,
   output logic [N-1:0]  pend_o,
   output logic [N-1:0]  full_o
);
   localparam int CW = $clog2(OCC_DEPTH + 1);

   initial begin
      if (OCC_DEPTH < 1) $error("iau_occ_bank: depth must be at least 1");
   end

   for (genvar g = 0; g < N; g++) begin : g_slot
      logic hit_inc, hit_dec;
      assign hit_inc = inc_en && (inc_idx == IW'(g));
      assign hit_dec = dec_en && (dec_idx == IW'(g));

      if (OCC_DEPTH == 1) begin : g_flag
         logic flag_q;
         always_ff @(posedge clk) begin
            if (!rst_n)       flag_q <= 1'b0;
            else if (hit_inc) flag_q <= 1'b1;
            else if (hit_dec) flag_q <= 1'b0;
         end
         assign pend_o[g] = flag_q;
         assign full_o[g] = flag_q;
      end else begin : g_count
         logic [CW-1:0] cnt_q;
         always_ff @(posedge clk) begin
            if (!rst_n) cnt_q <= '0;
            else begin
               case ({hit_inc, hit_dec})
                  2'b10:   cnt_q <= cnt_q + 1'b1;
                  2'b01:   cnt_q <= cnt_q - 1'b1;
                  default: cnt_q <= cnt_q;
               endcase
            end
         end
         assign pend_o[g] = (cnt_q != '0);
         assign full_o[g] = (cnt_q == CW'(OCC_DEPTH));
      end
   end
endmodule

// File: rtl/iau_svc_bank.sv
// In-service bit per vector with one set and one clear port
module iau_svc_bank #(
   parameter int N  = 256,
   parameter int IW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          set_en,
   input  logic [IW-1:0] set_idx,
   input  logic          clr_en,
   input  logic [IW-1:0] clr_idx,
   output logic [N-1:0]  svc_o
);
   for (genvar g = 0; g < N; g++) begin : g_bit
      logic b_q;
      always_ff @(posedge clk) begin
         if (!rst_n)                                   b_q <= 1'b0;
         else if (set_en && (set_idx == IW'(g)))       b_q <= 1'b1;
         else if (clr_en && (clr_idx == IW'(g)))       b_q <= 1'b0;
      end
      assign svc_o[g] = b_q;
   end
endmodule

// File: rtl/irq_accept_unit.sv
module irq_accept_unit
   import iau_pkg::*;
#(
   parameter int VEC_W     = 8,
   parameter int CLS_W     = 4,
   parameter int MIN_VEC   = 16,
   parameter int OCC_DEPTH = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             msg_valid,
   input  logic [VEC_W-1:0] msg_vec,
   input  logic             tpr_we,
   input  logic [VEC_W-1:0] tpr_wdata,
   input  logic             eoi,
   output logic             rsp_accept,
   output logic             rsp_reject,
   output logic             irq_pulse,
   output logic [VEC_W-1:0] irq_vec,
   output logic [VEC_W-1:0] proc_prio,
   output logic             illegal_err
);
   localparam int NUM_VEC = 1 << VEC_W;
   localparam int SUB_W   = VEC_W - CLS_W;

   initial begin
      if (CLS_W < 1 || CLS_W >= VEC_W) $error("irq_accept_unit: bad class width");
      if (MIN_VEC < 0 || MIN_VEC >= NUM_VEC) $error("irq_accept_unit: bad lowest vector");
   end

   logic [VEC_W-1:0]   tpr_q;
   logic [NUM_VEC-1:0] pend, full, svc;
   logic               pend_any, svc_any;
   logic [VEC_W-1:0]   pend_top, svc_top;
   logic [CLS_W-1:0]   tpr_cls, svc_cls, pend_cls, msg_cls;
   logic               disp_fire;
   iau_dec_e           dec;

   iau_occ_bank #(.N(NUM_VEC), .IW(VEC_W), .OCC_DEPTH(OCC_DEPTH)) u_occ (
      .clk     (clk),
      .rst_n   (rst_n),
      .inc_en  (msg_valid && dec_takes(dec)),
      .inc_idx (msg_vec),
      .dec_en  (disp_fire),
      .dec_idx (pend_top),
      .pend_o  (pend),
      .full_o  (full)
   );

   iau_svc_bank #(.N(NUM_VEC), .IW(VEC_W)) u_svc (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_en  (disp_fire),
      .set_idx (pend_top),
      .clr_en  (eoi && svc_any),
      .clr_idx (svc_top),
      .svc_o   (svc)
   );

   iau_top_finder #(.N(NUM_VEC), .IW(VEC_W)) u_pend_top (
      .bits_i (pend), .any_o (pend_any), .idx_o (pend_top)
   );

   iau_top_finder #(.N(NUM_VEC), .IW(VEC_W)) u_svc_top (
      .bits_i (svc), .any_o (svc_any), .idx_o (svc_top)
   );

   // Priority classes
   assign tpr_cls  = tpr_q[VEC_W-1 -: CLS_W];
   assign svc_cls  = svc_any ? svc_top[VEC_W-1 -: CLS_W] : '0;
   assign pend_cls = pend_top[VEC_W-1 -: CLS_W];
   assign msg_cls  = msg_vec[VEC_W-1 -: CLS_W];

   // Processor priority: task priority unless a higher-class handler runs
   assign proc_prio = (tpr_cls >= svc_cls) ? tpr_q : {svc_cls, {SUB_W{1'b0}}};

   assign disp_fire = pend_any && (pend_cls > proc_prio[VEC_W-1 -: CLS_W]);

   // Acceptance decision for the message of this cycle
   always_comb begin
      dec = DEC_NONE;
      if (msg_valid) begin
         if (msg_vec < VEC_W'(MIN_VEC))           dec = DEC_ILLEGAL;
         else if (pend[msg_vec] || svc[msg_vec]) dec = full[msg_vec] ? DEC_FULL : DEC_FOCUS;
         else if (msg_cls > tpr_cls)             dec = DEC_PRIO_OK;
         else                                    dec = DEC_PRIO_LOW;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tpr_q       <= '0;
         rsp_accept  <= 1'b0;
         rsp_reject  <= 1'b0;
         irq_pulse   <= 1'b0;
         irq_vec     <= '0;
         illegal_err <= 1'b0;
      end else begin
         if (tpr_we) tpr_q <= tpr_wdata;
         rsp_accept <= msg_valid && dec_takes(dec);
         rsp_reject <= msg_valid && !dec_takes(dec);
         irq_pulse  <= disp_fire;
         if (disp_fire) irq_vec <= pend_top;
         if (dec == DEC_ILLEGAL) illegal_err <= 1'b1;
      end
   end
endmodule

// File: rtl/iau_checker.sv
module iau_checker #(
   parameter int VEC_W   = 8,
   parameter int CLS_W   = 4,
   parameter int MIN_VEC = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             msg_valid,
   input logic [VEC_W-1:0] msg_vec,
   input logic             rsp_accept,
   input logic             rsp_reject,
   input logic             irq_pulse,
   input logic [VEC_W-1:0] irq_vec,
   input logic [VEC_W-1:0] proc_prio,
   input logic             illegal_err
);
   AST_RSP_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      !(rsp_accept && rsp_reject)); // R9
   AST_RSP_PER_MSG: assert property (@(posedge clk) disable iff (!rst_n)
      msg_valid |=> (rsp_accept || rsp_reject)); // R9
   AST_RSP_NO_MSG: assert property (@(posedge clk) disable iff (!rst_n)
      !msg_valid |=> !(rsp_accept || rsp_reject)); // R9
   AST_LOW_VEC_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
      (msg_valid && msg_vec < VEC_W'(MIN_VEC)) |=> (rsp_reject && illegal_err)); // R2
   AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      illegal_err |=> illegal_err); // R2
   AST_DISP_RAISES_PRIO: assert property (@(posedge clk) disable iff (!rst_n)
      irq_pulse |-> (proc_prio[VEC_W-1 -: CLS_W] >= irq_vec[VEC_W-1 -: CLS_W])); // R6
endmodule

bind irq_accept_unit iau_checker #(.VEC_W(VEC_W), .CLS_W(CLS_W), .MIN_VEC(MIN_VEC)) u_chk (.*);

// File: tb/irq_accept_unit_tb.sv
module irq_accept_unit_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       msg_valid = 1'b0;
   logic [7:0] msg_vec = '0;
   logic       tpr_we = 1'b0;
   logic [7:0] tpr_wdata = '0;
   logic       eoi = 1'b0;
   logic       rsp_accept, rsp_reject, irq_pulse, illegal_err;
   logic [7:0] irq_vec, proc_prio;

   int n_chk = 0;
   int n_err = 0;

   // Reference model state
   int         cnt_m [256];
   bit         svc_m [256];
   logic [7:0] tpr_m = '0;
   bit         err_m = 1'b0;
   logic [7:0] vec_m = '0;
   logic [7:0] recent [4] = '{8'h90, 8'hA3, 8'h57, 8'h2C};

   always #2 clk = ~clk;

   irq_accept_unit u_dut (.*);

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic int hi_pend();
      int r = -1;
      for (int i = 0; i < 256; i++) if (cnt_m[i] > 0) r = i;
      return r;
   endfunction

   function automatic int hi_svc();
      int r = -1;
      for (int i = 0; i < 256; i++) if (svc_m[i]) r = i;
      return r;
   endfunction

   function automatic logic [7:0] ppr_f();
      int s = hi_svc();
      logic [3:0] sc = (s >= 0) ? 4'(s >> 4) : 4'h0;
      return (tpr_m[7:4] >= sc) ? tpr_m : {sc, 4'h0};
   endfunction

   // Drive one cycle of stimulus at a falling edge, predict, check at the next
   task automatic step(input bit mv, input logic [7:0] mvec, input bit tw,
                       input logic [7:0] td, input bit e);
      int pt, st;
      bit fire, acc, rej;
      string tag;
      logic [7:0] pp;
      msg_valid = mv; msg_vec = mvec; tpr_we = tw; tpr_wdata = td; eoi = e;
      pt = hi_pend(); st = hi_svc(); pp = ppr_f();
      fire = (pt >= 0) && (4'(pt >> 4) > pp[7:4]);
      acc = 1'b0; rej = 1'b0; tag = "R9";
      if (mv) begin
         if (mvec < 8'h10) begin rej = 1'b1; err_m = 1'b1; tag = "R2"; end
         else if (cnt_m[mvec] > 0 || svc_m[mvec]) begin
            if (cnt_m[mvec] >= 2) begin rej = 1'b1; tag = "R5"; end
            else begin acc = 1'b1; tag = "R4"; end
         end else if (mvec[7:4] > tpr_m[7:4]) begin acc = 1'b1; tag = "R3"; end
         else begin rej = 1'b1; tag = "R3"; end
      end
      if (acc) begin
         cnt_m[mvec]++;
         recent[$urandom % 4] = mvec;
      end
      if (e && st >= 0) svc_m[st] = 1'b0;
      if (fire) begin cnt_m[pt]--; svc_m[pt] = 1'b1; vec_m = 8'(pt); end
      if (tw) tpr_m = td;
      @(negedge clk);
      chk(tag, int'(rsp_accept), int'(acc));
      chk(tag, int'(rsp_reject), int'(rej));
      chk("R9", int'(rsp_accept ^ rsp_reject), int'(mv));
      chk("R6", int'(irq_pulse), int'(fire));
      chk("R6", int'(irq_vec), int'(vec_m));
      chk("R7/R8", int'(proc_prio), int'(ppr_f()));
      chk("R2", int'(illegal_err), int'(err_m));
   endtask

   initial begin
      int r;
      logic [7:0] v;
      for (int i = 0; i < 256; i++) begin cnt_m[i] = 0; svc_m[i] = 1'b0; end
      r = $urandom(32'h1A5C);
      repeat (3) @(negedge clk);
      // R1: reset state
      chk("R1", int'(rsp_accept), 0);
      chk("R1", int'(rsp_reject), 0);
      chk("R1", int'(irq_pulse), 0);
      chk("R1", int'(illegal_err), 0);
      chk("R1", int'(proc_prio), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", int'(proc_prio), 0);

      // Directed corners
      step(1, 8'h80, 0, 8'h00, 0);   // R3 taken, dispatched next
      step(0, 8'h00, 1, 8'hF0, 0);   // R7 raise task priority
      step(1, 8'h30, 0, 8'h00, 0);   // R3 refused by task priority
      step(1, 8'h80, 0, 8'h00, 0);   // R4 focus while in service
      step(1, 8'h80, 0, 8'h00, 0);   // R4 second occurrence
      step(1, 8'h80, 0, 8'h00, 0);   // R5 third refused
      step(1, 8'h0F, 0, 8'h00, 0);   // R2 illegal vector
      step(0, 8'h00, 0, 8'h00, 1);   // R8 end of interrupt
      step(0, 8'h00, 1, 8'h00, 0);   // R6 lower priority, dispatch resumes
      step(0, 8'h00, 0, 8'h00, 0);
      step(0, 8'h00, 0, 8'h00, 1);   // R8
      step(0, 8'h00, 0, 8'h00, 0);   // R6 last occurrence
      step(1, 8'h10, 0, 8'h00, 0);   // R3 lowest legal vector

      // Constrained random
      for (int n = 0; n < 4000; n++) begin
         r = $urandom % 10;
         if (r < 2)      v = 8'($urandom % 16);
         else if (r < 5) v = recent[$urandom % 4];
         else            v = 8'($urandom % 256);
         step(($urandom % 2) == 0, v, ($urandom % 12) == 0, 8'($urandom % 256),
              ($urandom % 5) == 0);
      end
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      #(200000 * 4);
      n_err++;
      n_chk++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule